// File: doc/BRIEF.md
# DMA Channel Enable Control Bank

This block holds two enable bits for each of 16 DMA channels. One bit lets the channel's peripheral request through to the transfer engine. The other lets the channel's error flag raise an interrupt. Software reaches both sets of bits over a plain 32-bit register bus. It can write a whole bitmap at once, or it can use four single-channel alias registers. Each alias sets or clears one channel's bit, or all sixteen, so no read-modify-write is needed.

The transfer engine reports the end of each channel's major loop on `loop_done`, together with that descriptor's disable-request flag on `desc_dreq`. When both are high for a channel, the bank drops that channel's request enable by itself. The request outputs are combinational gates of the incoming peripheral requests. The error interrupt outputs are registered.

Register offsets (byte addresses):

| Offset | Access | Function |
|--------|--------|----------|
| 0x0C | read/write | request-enable bitmap |
| 0x14 | read/write | error-interrupt-enable bitmap |
| 0x18 | write-only | request-enable set alias |
| 0x1C | write-only | request-enable clear alias |
| 0x20 | write-only | error-enable set alias |
| 0x24 | write-only | error-enable clear alias |

There are no sequential control states. The alias decoder classifies each alias write as one of three kinds:
- `ALIAS_IDLE`: not addressed, or the no-op bit is set.
- `ALIAS_ONE`: a single channel.
- `ALIAS_ALL`: every channel.

It moves between these kinds on every cycle, purely from `bus_wr`, `bus_addr` and alias bits 7 and 6.

Top module: `dma_chan_enable_bank`

## Requirements
- R1: Sixteen channels each have one request-enable bit and one error-enable bit. In the bitmaps at 0x0C and 0x14, channel n sits at data bit n. A bitmap write replaces all sixteen bits, and the new value reads back from the next cycle on.
- R2: Data bits 31:16 of both bitmaps always read as zero, and values written to them are discarded.
- R3: After reset, every enable bit is zero, `dma_req` is zero for any `periph_req`, and `err_irq` is zero for any `err_flag`.
- R4: A write to a set or clear alias whose data bits 7 and 6 are zero selects the channel in data bits 3:0. The write sets or clears only that channel's bit, from the next cycle on. Data bits 5:4 and 31:8 are ignored.
- R5: Alias data bit 6 set (with bit 7 clear) applies the set or clear to all sixteen channels, whatever bits 3:0 hold.
- R6: Alias data bit 7 set makes the write a no-op, even when bit 6 is also set.
- R7: Reads of the four alias offsets, and of any unmapped offset, return zero.
- R8: `dma_req[n]` equals `periph_req[n]` AND request-enable n, in the same cycle. Error-enable bits have no effect on it.
- R9: A cycle with `loop_done[n]` and `desc_dreq[n]` both high clears request-enable n. `loop_done[n]` with `desc_dreq[n]` low leaves the bit unchanged.
- R10: When the R9 clear and a software bitmap or set-alias write hit the same bit in the same cycle, the bit ends up zero.
- R11: `err_irq[n]` is registered. In each cycle it shows `err_flag[n]` AND error-enable n as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| periph_req | input | 16 | Incoming peripheral DMA requests |
| dma_req | output | 16 | Gated requests to the transfer engine |
| loop_done | input | 16 | One-cycle pulse when a channel finishes its major loop |
| desc_dreq | input | 16 | Disable-request flag of the finishing descriptor |
| err_flag | input | 16 | Per-channel error indicators |
| err_irq | output | 16 | Per-channel error interrupt requests |

## Verification
Two functions can land in the same cycle: a software write to the request enables (set alias or bitmap) and the hardware clear at the end of a major loop. The bench provokes the clash by asserting the alias write for channel n together with `loop_done[n]` and `desc_dreq[n]` in one cycle. It does the same with an all-ones bitmap write against a mixed completion mask. It judges the result by reading the bitmap back: the colliding bits must be zero. A control case with `desc_dreq` low must show the software write taking effect.

// File: rtl/dceb_pkg.sv
package dceb_pkg;

    localparam int CH_COUNT = 16;
    localparam int BUS_AW   = 8;
    localparam int BUS_DW   = 32;

    localparam logic [7:0] OFS_REQ_MAP = 8'h0C;
    localparam logic [7:0] OFS_ERR_MAP = 8'h14;
    localparam logic [7:0] OFS_REQ_SET = 8'h18;
    localparam logic [7:0] OFS_REQ_CLR = 8'h1C;
    localparam logic [7:0] OFS_ERR_SET = 8'h20;
    localparam logic [7:0] OFS_ERR_CLR = 8'h24;

    localparam int ALIAS_NOP_BIT = 7;
    localparam int ALIAS_ALL_BIT = 6;
    localparam int ALIAS_COUNT   = 4;

    typedef enum logic [1:0] {
        ALIAS_IDLE,
        ALIAS_ONE,
        ALIAS_ALL
    } alias_kind_e;

    typedef struct packed {
        logic req_map_we;
        logic err_map_we;
        logic req_set;
        logic req_clr;
        logic err_set;
        logic err_clr;
    } bus_strobe_t;

endpackage

// File: rtl/dceb_bus_decode.sv
module dceb_bus_decode
    import dceb_pkg::*;
#(
    parameter int ADDR_W = BUS_AW
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output bus_strobe_t       stb
);

    always_comb begin
        stb            = '0;
        stb.req_map_we = wr && (addr == ADDR_W'(OFS_REQ_MAP));
        stb.err_map_we = wr && (addr == ADDR_W'(OFS_ERR_MAP));
        stb.req_set    = wr && (addr == ADDR_W'(OFS_REQ_SET));
        stb.req_clr    = wr && (addr == ADDR_W'(OFS_REQ_CLR));
        stb.err_set    = wr && (addr == ADDR_W'(OFS_ERR_SET));
        stb.err_clr    = wr && (addr == ADDR_W'(OFS_ERR_CLR));
    end

endmodule

// File: rtl/dceb_alias_decode.sv
module dceb_alias_decode
    import dceb_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              hit,
    input  logic              nop_bit,
    input  logic              all_bit,
    input  logic [CH_W-1:0]   ch_sel,
    output logic [NUM_CH-1:0] mask
);

    alias_kind_e kind;

    // Classify: no-op outranks the all-channel bit
    always_comb begin
        if (!hit || nop_bit) begin
            kind = ALIAS_IDLE;
        end else if (all_bit) begin
            kind = ALIAS_ALL;
        end else begin
            kind = ALIAS_ONE;
        end
    end

    always_comb begin
        mask = '0;
        unique case (kind)
            ALIAS_IDLE: mask = '0;
            ALIAS_ONE:  mask[ch_sel] = 1'b1;
            ALIAS_ALL:  mask = '1;
            default:    mask = '0;
        endcase
    end

endmodule

// File: rtl/dceb_enable_reg.sv
module dceb_enable_reg
    import dceb_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_we,
    input  logic [NUM_CH-1:0] map_wdata,
    input  logic [NUM_CH-1:0] set_mask,
    input  logic [NUM_CH-1:0] clr_mask,
    input  logic [NUM_CH-1:0] hw_clr,
    output logic [NUM_CH-1:0] q
);

    logic [NUM_CH-1:0] q_nxt;

    // Software first, hardware clear applied last so it wins
    always_comb begin
        q_nxt = q;
        if (map_we) begin
            q_nxt = map_wdata;
        end
        q_nxt = (q_nxt | set_mask) & ~clr_mask;
        q_nxt = q_nxt & ~hw_clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_nxt;
        end
    end

endmodule

// File: rtl/dma_chan_enable_bank.sv
module dma_chan_enable_bank
    import dceb_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int ADDR_W = BUS_AW,
    parameter int DATA_W = BUS_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] periph_req,
    output logic [NUM_CH-1:0] dma_req,
    input  logic [NUM_CH-1:0] loop_done,
    input  logic [NUM_CH-1:0] desc_dreq,
    input  logic [NUM_CH-1:0] err_flag,
    output logic [NUM_CH-1:0] err_irq
);

    localparam int CH_W = $clog2(NUM_CH);

    bus_strobe_t       stb;
    logic [NUM_CH-1:0] req_en_q;
    logic [NUM_CH-1:0] err_en_q;
    logic [NUM_CH-1:0] alias_mask [ALIAS_COUNT];
    logic [ALIAS_COUNT-1:0] alias_hit;
    logic              unused_wdata;

    assign unused_wdata = ^{bus_wdata[DATA_W-1:8], bus_wdata[5:CH_W]};

    dceb_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr   (bus_wr),
        .addr (bus_addr),
        .stb  (stb)
    );

    // Index 0: req set, 1: req clear, 2: err set, 3: err clear
    assign alias_hit = {stb.err_clr, stb.err_set, stb.req_clr, stb.req_set};

    for (genvar g = 0; g < ALIAS_COUNT; g++) begin : g_alias
        dceb_alias_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_alias (
            .hit     (alias_hit[g]),
            .nop_bit (bus_wdata[ALIAS_NOP_BIT]),
            .all_bit (bus_wdata[ALIAS_ALL_BIT]),
            .ch_sel  (bus_wdata[CH_W-1:0]),
            .mask    (alias_mask[g])
        );
    end

    dceb_enable_reg #(.NUM_CH(NUM_CH)) u_req_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_we    (stb.req_map_we),
        .map_wdata (bus_wdata[NUM_CH-1:0]),
        .set_mask  (alias_mask[0]),
        .clr_mask  (alias_mask[1]),
        .hw_clr    (loop_done & desc_dreq),
        .q         (req_en_q)
    );

    dceb_enable_reg #(.NUM_CH(NUM_CH)) u_err_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_we    (stb.err_map_we),
        .map_wdata (bus_wdata[NUM_CH-1:0]),
        .set_mask  (alias_mask[2]),
        .clr_mask  (alias_mask[3]),
        .hw_clr    ('0),
        .q         (err_en_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_REQ_MAP)) begin
            bus_rdata[NUM_CH-1:0] = req_en_q;
        end else if (bus_addr == ADDR_W'(OFS_ERR_MAP)) begin
            bus_rdata[NUM_CH-1:0] = err_en_q;
        end
    end

    assign dma_req = periph_req & req_en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_irq <= '0;
        end else begin
            err_irq <= err_flag & err_en_q;
        end
    end

endmodule

// File: rtl/dceb_checker.sv
module dceb_checker
    import dceb_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int ADDR_W = BUS_AW,
    parameter int DATA_W = BUS_DW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] loop_done,
    input logic [NUM_CH-1:0] desc_dreq,
    input logic [NUM_CH-1:0] err_flag,
    input logic [NUM_CH-1:0] err_irq,
    input logic [NUM_CH-1:0] req_en,
    input logic [NUM_CH-1:0] err_en
);

    localparam int CH_W = $clog2(NUM_CH);

    logic alias_addr;
    logic err_alias_addr;
    assign alias_addr = (bus_addr == ADDR_W'(OFS_REQ_SET)) || (bus_addr == ADDR_W'(OFS_REQ_CLR)) ||
                        (bus_addr == ADDR_W'(OFS_ERR_SET)) || (bus_addr == ADDR_W'(OFS_ERR_CLR));
    assign err_alias_addr = (bus_addr == ADDR_W'(OFS_ERR_SET)) || (bus_addr == ADDR_W'(OFS_ERR_CLR));

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_CH] == '0); // R2

    AST_SET_ONE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_ERR_SET) && bus_wdata[7:6] == 2'b00)
        |=> err_en[$past(bus_wdata[CH_W-1:0])]); // R4

    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && err_alias_addr && bus_wdata[ALIAS_NOP_BIT]) |=> $stable(err_en)); // R6

    AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        alias_addr |-> bus_rdata == '0); // R7

    AST_AUTOCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(loop_done & desc_dreq)) |=> ((req_en & $past(loop_done & desc_dreq)) == '0)); // R10

    AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == $past(err_flag & err_en)); // R11

endmodule

bind dma_chan_enable_bank dceb_checker #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .loop_done (loop_done),
    .desc_dreq (desc_dreq),
    .err_flag  (err_flag),
    .err_irq   (err_irq),
    .req_en    (req_en_q),
    .err_en    (err_en_q)
);

// File: tb/dma_chan_enable_bank_tb_top.sv
module dma_chan_enable_bank_tb_top;

    localparam logic [7:0] A_REQ_MAP = 8'h0C;
    localparam logic [7:0] A_ERR_MAP = 8'h14;
    localparam logic [7:0] A_REQ_SET = 8'h18;
    localparam logic [7:0] A_REQ_CLR = 8'h1C;
    localparam logic [7:0] A_ERR_SET = 8'h20;
    localparam logic [7:0] A_ERR_CLR = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [15:0] periph_i = '0;
    logic [15:0] dma_req_o;
    logic [15:0] done_i = '0;
    logic [15:0] dreq_i = '0;
    logic [15:0] eflag_i = '0;
    logic [15:0] irq_o;

    int vectors = 0;
    int errors  = 0;
    logic [15:0] mreq = '0;
    logic [15:0] merr = '0;

    always #2 clk = ~clk;

    dma_chan_enable_bank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (wr_i),
        .bus_addr   (addr_i),
        .bus_wdata  (wdata_i),
        .bus_rdata  (rdata_o),
        .periph_req (periph_i),
        .dma_req    (dma_req_o),
        .loop_done  (done_i),
        .desc_dreq  (dreq_i),
        .err_flag   (eflag_i),
        .err_irq    (irq_o)
    );

    function automatic logic [15:0] alias_m(input logic [7:0] b);
        if (b[7]) return 16'h0000;
        if (b[6]) return 16'hFFFF;
        return 16'(1) << b[3:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model update for a software write, per R1, R2, R4, R5, R6
    function automatic void model_wr(input logic [7:0] a, input logic [31:0] d);
        case (a)
            A_REQ_MAP: mreq = d[15:0];
            A_ERR_MAP: merr = d[15:0];
            A_REQ_SET: mreq = mreq | alias_m(d[7:0]);
            A_REQ_CLR: mreq = mreq & ~alias_m(d[7:0]);
            A_ERR_SET: merr = merr | alias_m(d[7:0]);
            A_ERR_CLR: merr = merr & ~alias_m(d[7:0]);
            default: ;
        endcase
    endfunction

    task automatic sw_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_i = 1'b0; wdata_i = '0;
        model_wr(a, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic verify(input string tag);
        logic [31:0] v;
        rd(A_REQ_MAP, v); chk({tag, " req map"}, v, {16'h0, mreq});
        rd(A_ERR_MAP, v); chk({tag, " err map"}, v, {16'h0, merr});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [15:0] pats [8];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5A5; pats[3] = 16'h5A5A;
        pats[4] = 16'h8001; pats[5] = 16'h0F0F; pats[6] = 16'h1234; pats[7] = 16'hFE7F;

        // R3: reset state
        repeat (3) @(negedge clk);
        periph_i = 16'hFFFF; eflag_i = 16'hFFFF;
        rst_n = 1'b1;
        verify("R3");
        chk("R3 dma_req", {16'h0, dma_req_o}, 32'h0);
        @(negedge clk);
        chk("R3 err_irq", {16'h0, irq_o}, 32'h0);
        periph_i = '0; eflag_i = '0;
        @(negedge clk);

        // R1, R2: bitmap writes, upper half discarded
        for (int i = 0; i < 8; i++) begin
            logic [31:0] w;
            w = {pats[7-i] ^ 16'h3C3C, pats[i]};
            sw_write(A_REQ_MAP, w);
            sw_write(A_ERR_MAP, ~w);
            verify("R1");
            rd(A_REQ_MAP, v); chk("R2 req upper", {16'h0, v[31:16]}, 32'h0);
            rd(A_ERR_MAP, v); chk("R2 err upper", {16'h0, v[31:16]}, 32'h0);
        end

        // R4: single-channel set and clear on both banks
        for (int ch = 0; ch < 16; ch++) begin
            sw_write(A_REQ_MAP, 32'h0000_6C39);
            sw_write(A_ERR_MAP, 32'h0000_93C6);
            sw_write(A_REQ_SET, 32'hFFFF_FF00 | 32'(ch) | 32'h30);
            sw_write(A_ERR_SET, 32'(ch));
            verify("R4 set");
            sw_write(A_REQ_CLR, 32'(ch) | 32'h10);
            sw_write(A_ERR_CLR, 32'hABCD_0000 | 32'(ch) | 32'h20);
            verify("R4 clr");
        end

        // R5: all-channel aliases
        for (int ch = 0; ch < 16; ch += 5) begin
            sw_write(A_REQ_MAP, 32'h0);
            sw_write(A_ERR_MAP, 32'h0);
            sw_write(A_REQ_SET, 32'h40 | 32'(ch));
            sw_write(A_ERR_SET, 32'h40 | 32'(15 - ch));
            verify("R5 set all");
            sw_write(A_ERR_CLR, 32'h40 | 32'(ch));
            verify("R5 clr err all");
            sw_write(A_REQ_CLR, 32'h4F);
            verify("R5 clr req all");
        end

        // R6: no-op writes leave both banks unchanged
        sw_write(A_REQ_MAP, 32'h0000_C3A5);
        sw_write(A_ERR_MAP, 32'h0000_5AC3);
        for (int ch = 0; ch < 16; ch++) begin
            sw_write(A_REQ_SET, 32'h80 | 32'(ch));
            sw_write(A_REQ_CLR, 32'hC0 | 32'(ch));
            sw_write(A_ERR_SET, 32'hC0 | 32'(ch));
            sw_write(A_ERR_CLR, 32'h80 | 32'(ch));
            verify("R6");
        end

        // R7: alias and unmapped reads are zero
        sw_write(A_REQ_MAP, 32'hFFFF_FFFF);
        sw_write(A_ERR_MAP, 32'hFFFF_FFFF);
        rd(A_REQ_SET, v); chk("R7 req set read", v, 32'h0);
        rd(A_REQ_CLR, v); chk("R7 req clr read", v, 32'h0);
        rd(A_ERR_SET, v); chk("R7 err set read", v, 32'h0);
        rd(A_ERR_CLR, v); chk("R7 err clr read", v, 32'h0);
        rd(8'h00, v);     chk("R7 unmapped 00", v, 32'h0);
        rd(8'h10, v);     chk("R7 unmapped 10", v, 32'h0);
        rd(8'hFC, v);     chk("R7 unmapped FC", v, 32'h0);

        // R8: combinational request gating, error enables irrelevant
        for (int i = 0; i < 8; i++) begin
            sw_write(A_REQ_MAP, {16'h0, pats[i]});
            sw_write(A_ERR_MAP, {16'h0, ~pats[i]});
            for (int j = 0; j < 8; j++) begin
                periph_i = pats[j] ^ 16'(j * 16'h1111);
                #1;
                chk("R8", {16'h0, dma_req_o}, {16'h0, periph_i & mreq});
            end
            periph_i = '0;
        end

        // R9: major-loop completion clears only when the flag is set
        for (int i = 0; i < 16; i++) begin
            logic [15:0] d, f;
            d = 16'(i * 16'h3B1F) | (16'(1) << i);
            f = 16'(i * 16'h2C95) ^ 16'h00FF;
            sw_write(A_REQ_MAP, 32'h0000_FFFF);
            @(negedge clk);
            done_i = d; dreq_i = f;
            @(negedge clk);
            done_i = '0; dreq_i = '0;
            mreq = mreq & ~(d & f);
            verify("R9");
        end

        // R10: hardware clear beats same-cycle software write
        for (int ch = 0; ch < 16; ch++) begin
            sw_write(A_REQ_MAP, 32'h0);
            @(negedge clk);
            wr_i = 1'b1; addr_i = A_REQ_SET; wdata_i = 32'(ch);
            done_i = 16'(1) << ch; dreq_i = 16'(1) << ch;
            @(negedge clk);
            wr_i = 1'b0; wdata_i = '0; done_i = '0; dreq_i = '0;
            rd(A_REQ_MAP, v); chk("R10 alias collision", v, 32'h0);
            mreq = '0;
            // control: flag low, software set must take effect
            @(negedge clk);
            wr_i = 1'b1; addr_i = A_REQ_SET; wdata_i = 32'(ch);
            done_i = 16'(1) << ch; dreq_i = '0;
            @(negedge clk);
            wr_i = 1'b0; wdata_i = '0; done_i = '0;
            rd(A_REQ_MAP, v); chk("R10 flag low control", v, 32'(16'(1) << ch));
            mreq = 16'(1) << ch;
        end
        for (int i = 1; i < 8; i++) begin
            @(negedge clk);
            wr_i = 1'b1; addr_i = A_REQ_MAP; wdata_i = 32'hFFFF_FFFF;
            done_i = pats[i]; dreq_i = pats[(i + 3) % 8];
            @(negedge clk);
            wr_i = 1'b0; wdata_i = '0; done_i = '0; dreq_i = '0;
            mreq = 16'hFFFF & ~(pats[i] & pats[(i + 3) % 8]);
            rd(A_REQ_MAP, v); chk("R10 map collision", v, {16'h0, mreq});
        end

        // R11: registered error interrupt, one-cycle latency
        for (int e = 0; e < 4; e++) begin
            logic [15:0] prev;
            sw_write(A_ERR_MAP, {16'h0, pats[e + 1]});
            eflag_i = '0;
            @(negedge clk);
            prev = '0;
            for (int k = 0; k < 16; k++) begin
                logic [15:0] f;
                f = 16'(k * 16'h4F3B) ^ 16'(e * 16'h0707);
                eflag_i = f;
                #1;
                chk("R11 before edge", {16'h0, irq_o}, {16'h0, prev});
                @(negedge clk);
                chk("R11 after edge", {16'h0, irq_o}, {16'h0, f & merr});
                prev = f & merr;
            end
            eflag_i = '0;
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule